// File: doc/BRIEF.md
# Processor Power State Sequencer

This block sits on the processor side of a point-to-point system bus and tracks which power state the core is in: Working, Halt, Stop Grant or Probe. It reacts to a halt-instruction strobe, a stop-clock request, a vector of wake events (interrupt, NMI, SMI, INIT), a reset input, a probe request from the system controller and the bus-connected status. From these it decides when to ask for a bus connect, when to emit the Stop Grant special cycle, and which low-power state to return to once probe service is over.

The stop-clock request can only be honoured on a connected bus. The sequencer therefore waits in a hidden pending phase, asking for a connect, and issues the special cycle only once the bus is up. During that phase the reported state stays the one the request came from. Probe service remembers whether it came from Halt or from Stop Grant, and the return waits until the system controller has dropped the bus connection.

All inputs are synchronous to `clk`. `reset_i` is synchronous, active high, and takes priority over every other transition.

Top module: `pwr_state_seq`

## Requirements
- R1: While `reset_i` is high at a clock edge, the reported state after that edge is Working (`state_o` = 2'b00), with `conn_req_o` and `sg_cycle_o` low, whatever the other inputs are.
- R2: In Working with `stpclk_i` low, a high `halt_i` moves the reported state to Halt (2'b01) after that edge.
- R3: In Halt with `stpclk_i` low, any set bit of `wake_i` (bit 0 interrupt, bit 1 NMI, bit 2 SMI, bit 3 INIT) moves the state to Working after that edge. Wake bits have no effect while a stop-clock request is pending.
- R4: `stpclk_i` high in Working or Halt starts a pending phase after that edge. In this phase `state_o` keeps the original code and `conn_req_o` equals the inverse of `bus_conn_i`. `conn_req_o` is never high while `bus_conn_i` is high.
- R5: In the pending phase, an edge with `stpclk_i` and `bus_conn_i` both high moves the state to Stop Grant (2'b10). `sg_cycle_o` is high for exactly the first cycle after that edge.
- R6: In the pending phase, an edge with `stpclk_i` low cancels the request. The state returns to its origin, `conn_req_o` drops and no special cycle is emitted.
- R7: In Stop Grant, `stpclk_i` low at an edge moves the state to Halt.
- R8: `probe_req_i` high in Halt (without stop-clock or wake) or in Stop Grant (with `stpclk_i` still high) moves the state to Probe (2'b11). In Working it has no effect.
- R9: The state leaves Probe only on an edge with `probe_req_i` low and `bus_conn_i` low. It then returns to the state that Probe was entered from.
- R10: `sg_cycle_o` rises only on the entry into Stop Grant from the pending phase. A return to Stop Grant from Probe emits no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset_i | input | 1 | Synchronous reset, highest priority |
| halt_i | input | 1 | Halt-instruction strobe |
| stpclk_i | input | 1 | Stop-clock request level |
| wake_i | input | WAKE_N (4) | Wake events: interrupt, NMI, SMI, INIT |
| probe_req_i | input | 1 | Probe service requested |
| bus_conn_i | input | 1 | System bus is connected |
| state_o | output | 2 | Reported power state code |
| conn_req_o | output | 1 | Request a system bus connect |
| sg_cycle_o | output | 1 | One-cycle Stop Grant special-cycle strobe |

## Verification
Every state change is registered, so `state_o` and `sg_cycle_o` reflect an input pattern in the cycle right after the edge that samples it. `conn_req_o` is the pending state combined with the live `bus_conn_i` in that same cycle. The driver applies one input pattern per cycle on the falling edge and queues the outputs due after the next rising edge. The monitor pops and compares each entry one nanosecond after that rising edge, while the inputs are still held. Each expectation thus lines up with exactly one sampling edge, including the cancel, no-strobe and reset-priority cases.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PS_WORK  = 3'd0,
    PS_HALT  = 3'd1,
    PS_PEND  = 3'd2,
    PS_STOPG = 3'd3,
    PS_PROBE = 3'd4
  } seq_st_t;

  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] CODE_WORK  = 2'b00;
  localparam logic [CODE_W-1:0] CODE_HALT  = 2'b01;
  localparam logic [CODE_W-1:0] CODE_STOPG = 2'b10;
  localparam logic [CODE_W-1:0] CODE_PROBE = 2'b11;

  // Externally visible code; the pending phase reports its origin.
  function automatic logic [CODE_W-1:0] report_code(seq_st_t st, logic from_halt);
    case (st)
      PS_WORK:  return CODE_WORK;
      PS_HALT:  return CODE_HALT;
      PS_PEND:  return from_halt ? CODE_HALT : CODE_WORK;
      PS_STOPG: return CODE_STOPG;
      PS_PROBE: return CODE_PROBE;
      default:  return CODE_WORK;
    endcase
  endfunction

  function automatic logic need_connect(seq_st_t st, logic bus_up);
    return (st == PS_PEND) && !bus_up;
  endfunction

  function automatic logic probe_can_return(logic probe_req, logic bus_up);
    return !probe_req && !bus_up;
  endfunction

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic    clk,
  input  logic    reset_i,
  input  logic    halt_i,
  input  logic    stpclk_i,
  input  logic    wake_any_i,
  input  logic    probe_req_i,
  input  logic    bus_conn_i,
  input  logic    origin_halt_i,
  output seq_st_t st_o,
  output logic    sg_enter_o,
  output logic    capture_o,
  output logic    capture_val_o
);

  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      PS_WORK: begin
        if (stpclk_i)    st_d = PS_PEND;
        else if (halt_i) st_d = PS_HALT;
      end
      PS_HALT: begin
        if (stpclk_i)         st_d = PS_PEND;
        else if (wake_any_i)  st_d = PS_WORK;
        else if (probe_req_i) st_d = PS_PROBE;
      end
      PS_PEND: begin
        if (!stpclk_i)       st_d = origin_halt_i ? PS_HALT : PS_WORK;
        else if (bus_conn_i) st_d = PS_STOPG;
      end
      PS_STOPG: begin
        if (!stpclk_i)        st_d = PS_HALT;
        else if (probe_req_i) st_d = PS_PROBE;
      end
      PS_PROBE: begin
        if (probe_can_return(probe_req_i, bus_conn_i))
          st_d = origin_halt_i ? PS_HALT : PS_STOPG;
      end
      default: st_d = PS_WORK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (reset_i) st_q <= PS_WORK;
    else         st_q <= st_d;
  end

  assign st_o          = st_q;
  assign sg_enter_o    = !reset_i && (st_q == PS_PEND) && (st_d == PS_STOPG);
  assign capture_o     = !reset_i && (st_d != st_q) &&
                         ((st_d == PS_PEND) || (st_d == PS_PROBE));
  assign capture_val_o = (st_q == PS_HALT);

  // R9: probe service is held while the request or the bus connection persists
  p_probe_hold_r9: assert property (@(posedge clk) disable iff (reset_i)
    (st_q == PS_PROBE && (probe_req_i || bus_conn_i)) |=> (st_q == PS_PROBE));

  // R3: a wake event in Halt without stop-clock returns to Working
  p_wake_r3: assert property (@(posedge clk) disable iff (reset_i)
    (st_q == PS_HALT && !stpclk_i && wake_any_i) |=> (st_q == PS_WORK));

  // R6: dropping stop-clock while pending never reaches Stop Grant
  p_cancel_r6: assert property (@(posedge clk) disable iff (reset_i)
    (st_q == PS_PEND && !stpclk_i) |=> (st_q != PS_STOPG));

endmodule

// File: rtl/pwr_seq_origin.sv
module pwr_seq_origin (
  input  logic clk,
  input  logic reset_i,
  input  logic capture_i,
  input  logic capture_val_i,
  output logic origin_halt_o
);

  logic origin_q;

  // One bit serves both the pending phase and probe: they never overlap.
  always_ff @(posedge clk) begin
    if (reset_i)        origin_q <= 1'b0;
    else if (capture_i) origin_q <= capture_val_i;
  end

  assign origin_halt_o = origin_q;

endmodule

// File: rtl/pwr_seq_out.sv
module pwr_seq_out
  import pwr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              reset_i,
  input  seq_st_t           st_i,
  input  logic              origin_halt_i,
  input  logic              bus_conn_i,
  input  logic              sg_enter_i,
  output logic [CODE_W-1:0] state_o,
  output logic              conn_req_o,
  output logic              sg_cycle_o
);

  logic sg_q;

  always_ff @(posedge clk) begin
    if (reset_i) sg_q <= 1'b0;
    else         sg_q <= sg_enter_i;
  end

  assign state_o    = report_code(st_i, origin_halt_i);
  assign conn_req_o = need_connect(st_i, bus_conn_i);
  assign sg_cycle_o = sg_q;

  // R5: the special-cycle strobe lasts one clock
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (reset_i)
    sg_q |=> !sg_q);

  // R10: the strobe is only seen together with Stop Grant
  p_strobe_state_r10: assert property (@(posedge clk) disable iff (reset_i)
    sg_q |-> (state_o == CODE_STOPG));

  // R4: no connect request on an already connected bus
  p_conn_disc_r4: assert property (@(posedge clk) disable iff (reset_i)
    conn_req_o |-> !bus_conn_i);

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pwr_seq_pkg::*;
#(
  parameter int WAKE_N = 4
) (
  input  logic              clk,
  input  logic              reset_i,
  input  logic              halt_i,
  input  logic              stpclk_i,
  input  logic [WAKE_N-1:0] wake_i,
  input  logic              probe_req_i,
  input  logic              bus_conn_i,
  output logic [1:0]        state_o,
  output logic              conn_req_o,
  output logic              sg_cycle_o
);

  localparam int CHAIN_W = WAKE_N + 1;

  logic [CHAIN_W-1:0] wake_chain;
  assign wake_chain[0] = 1'b0;
  for (genvar gi = 0; gi < WAKE_N; gi++) begin : g_wake
    assign wake_chain[gi+1] = wake_chain[gi] | wake_i[gi];
  end

  logic    wake_any;
  seq_st_t st;
  logic    sg_enter, capture, capture_val, origin_halt;

  assign wake_any = wake_chain[WAKE_N];

  pwr_seq_fsm u_fsm (
    .clk           (clk),
    .reset_i       (reset_i),
    .halt_i        (halt_i),
    .stpclk_i      (stpclk_i),
    .wake_any_i    (wake_any),
    .probe_req_i   (probe_req_i),
    .bus_conn_i    (bus_conn_i),
    .origin_halt_i (origin_halt),
    .st_o          (st),
    .sg_enter_o    (sg_enter),
    .capture_o     (capture),
    .capture_val_o (capture_val)
  );

  pwr_seq_origin u_origin (
    .clk           (clk),
    .reset_i       (reset_i),
    .capture_i     (capture),
    .capture_val_i (capture_val),
    .origin_halt_o (origin_halt)
  );

  pwr_seq_out u_out (
    .clk           (clk),
    .reset_i       (reset_i),
    .st_i          (st),
    .origin_halt_i (origin_halt),
    .bus_conn_i    (bus_conn_i),
    .sg_enter_i    (sg_enter),
    .state_o       (state_o),
    .conn_req_o    (conn_req_o),
    .sg_cycle_o    (sg_cycle_o)
  );

  // R1: reset wins over every other input
  p_reset_r1: assert property (@(posedge clk) disable iff (reset_i)
    $fell(reset_i) |-> (state_o == 2'b00 && !sg_cycle_o));

endmodule

// File: tb/pwr_state_seq_test.sv
`timescale 1ns/1ps
module pwr_state_seq_test;

  logic       clk = 1'b0;
  logic       reset_i = 1'b1;
  logic       halt_i = 1'b0, stpclk_i = 1'b0, probe_req_i = 1'b0, bus_conn_i = 1'b0;
  logic [3:0] wake_i = 4'b0;
  logic [1:0] state_o;
  logic       conn_req_o, sg_cycle_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] st;
    logic       cr;
    logic       sg;
    string      tag;
  } exp_t;
  exp_t sb[$];

  localparam logic [1:0] WK = 2'b00, HL = 2'b01, SG = 2'b10, PR = 2'b11;

  always #2.5 clk = ~clk;

  pwr_state_seq uut (
    .clk(clk), .reset_i(reset_i), .halt_i(halt_i), .stpclk_i(stpclk_i),
    .wake_i(wake_i), .probe_req_i(probe_req_i), .bus_conn_i(bus_conn_i),
    .state_o(state_o), .conn_req_o(conn_req_o), .sg_cycle_o(sg_cycle_o)
  );

  task automatic step(input logic r, input logic h, input logic s, input logic [3:0] w,
                      input logic p, input logic b, input logic [1:0] es,
                      input logic ec, input logic eg, input string tag);
    exp_t e;
    @(negedge clk);
    reset_i = r; halt_i = h; stpclk_i = s; wake_i = w; probe_req_i = p; bus_conn_i = b;
    e.st = es; e.cr = ec; e.sg = eg; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: one entry per rising edge, compared 1 ns later.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0 && !done) begin
      e = sb.pop_front();
      checks++;
      if (state_o !== e.st || conn_req_o !== e.cr || sg_cycle_o !== e.sg) begin
        errors++;
        $display("FAIL %s: got state=%b conn=%b sg=%b, expected state=%b conn=%b sg=%b",
                 e.tag, state_o, conn_req_o, sg_cycle_o, e.st, e.cr, e.sg);
      end
    end
  end

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) step(1,0,0,4'h0,0,0, WK,0,0, "R1 reset");
    step(0,0,0,4'h0,0,0, WK,0,0, "R1 idle after reset");
    // R2 / R3 halt and wake
    step(0,1,0,4'h0,0,0, HL,0,0, "R2 halt");
    step(0,0,0,4'h1,0,0, WK,0,0, "R3 interrupt wake");
    step(0,1,0,4'h0,0,0, HL,0,0, "R2 halt again");
    step(0,0,0,4'h8,0,0, WK,0,0, "R3 init wake");
    step(0,1,0,4'h0,0,0, HL,0,0, "R2 halt third");
    // R4 pending from Halt, wake ignored
    step(0,0,1,4'h0,0,0, HL,1,0, "R4 pending from halt");
    step(0,0,1,4'h1,0,0, HL,1,0, "R4 wake ignored while pending");
    // R5 connect done, strobe once
    step(0,0,1,4'h0,0,1, SG,0,1, "R5 stop grant entry strobe");
    step(0,0,1,4'h0,0,1, SG,0,0, "R5 strobe one cycle");
    step(0,0,1,4'h0,0,0, SG,0,0, "R5 stop grant hold");
    // R8 / R9 / R10 probe from Stop Grant
    step(0,0,1,4'h0,1,0, PR,0,0, "R8 probe from stop grant");
    step(0,0,1,4'h0,1,1, PR,0,0, "R9 probe while requested");
    step(0,0,1,4'h0,0,1, PR,0,0, "R9 wait for disconnect");
    step(0,0,1,4'h0,0,0, SG,0,0, "R10 return to stop grant no strobe");
    // R7
    step(0,0,0,4'h0,0,0, HL,0,0, "R7 stop clock released");
    // probe from Halt
    step(0,0,0,4'h0,1,0, PR,0,0, "R8 probe from halt");
    step(0,0,0,4'h0,0,0, HL,0,0, "R9 return to halt");
    step(0,0,0,4'h2,0,0, WK,0,0, "R3 nmi wake");
    step(0,0,0,4'h0,1,0, WK,0,0, "R8 probe ignored in working");
    // R6 cancel from Working
    step(0,0,1,4'h0,0,0, WK,1,0, "R4 pending from working");
    step(0,0,0,4'h0,0,0, WK,0,0, "R6 cancel to working");
    step(0,0,0,4'h0,0,0, WK,0,0, "R6 no strobe after cancel");
    // already connected bus
    step(0,0,1,4'h0,0,1, WK,0,0, "R4 pending on connected bus");
    step(0,0,1,4'h0,0,1, SG,0,1, "R5 strobe on connected bus");
    step(0,0,1,4'h0,0,1, SG,0,0, "R5 single strobe");
    // R1 priority
    step(1,0,1,4'h0,1,1, WK,0,0, "R1 reset priority in stop grant");
    step(0,0,0,4'h0,0,0, WK,0,0, "R1 working after reset");
    // cancel back to Halt
    step(0,1,0,4'h0,0,0, HL,0,0, "R2 halt");
    step(0,0,1,4'h0,0,0, HL,1,0, "R4 pending from halt");
    step(0,0,0,4'h0,0,0, HL,0,0, "R6 cancel to halt");
    step(0,0,0,4'h4,0,0, WK,0,0, "R3 smi wake");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule